// File: doc/BRIEF.md
# Packed-Lane Halving Add/Subtract Unit

This unit performs integer arithmetic on every lane of two packed operand vectors at once and halves each result, so no lane can overflow. Three operations are offered: a truncating halving add, a halving add that rounds by adding one before the halving, and a truncating halving subtract. Each lane is taken as 8, 16 or 32 bits, chosen per request, and as signed or unsigned.

The vector width is a build-time parameter, either 64 or 128 bits. This gives 8, 4 or 2 lanes, or 16, 8 or 4 lanes. Inside each lane the operands are widened by one bit: sign-extended when the signed select is high and zero-extended when it is low. The sum or difference is formed at that width, and the upper lane-width bits are kept as the result. A request is accepted whenever `in_valid` is high. Its result is registered and appears with `out_valid` one cycle later.

Top module: `hsv_halving_unit`

## Requirements
- R1: With `op_sel` = 2'b00 each lane returns floor((a+b)/2) computed without overflow, for example signed 8-bit 0xF0 and 0xF3 give 0xF1, and 0xF1 and 0xF3 give 0xF2.
- R2: With `op_sel` = 2'b01 each lane returns floor((a+b+1)/2), for example signed 8-bit 0xF0 and 0xF3 give 0xF2.
- R3: With `op_sel` = 2'b10 each lane returns floor((a-b)/2) truncated to the lane width, so an unsigned negative difference wraps, for example unsigned 8-bit 0xF0 minus 0xF3 gives 0xFE.
- R4: `is_signed` = 1 sign-extends each lane operand and `is_signed` = 0 zero-extends it, so 8-bit 0x80 halving-added to 0x00 gives 0xC0 signed and 0x40 unsigned.
- R5: `lane_sz` selects the lane width: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 is 32 bits and 2'b11 also acts as 32 bits. Lane i occupies bits [i*W +: W], and no carry or borrow crosses a lane boundary.
- R6: The unused operation code `op_sel` = 2'b11 behaves as the truncating halving add.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_data` then holds that request's result. Back-to-back requests are accepted on every cycle.
- R8: After reset `out_valid` and `out_data` are zero, and while `in_valid` is low `out_data` keeps its value whatever the other inputs do.
- R9: Equal operands give zero under halving subtract and give the operand itself under truncating halving add.
- R10: Extreme operands cannot overflow: unsigned 8-bit 0xFF and 0xFF give 0xFF under either add, and signed 8-bit 0x80 and 0x80 give 0x80 under halving add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 2 | 00 halving add, 01 rounding halving add, 10 halving subtract, 11 as 00 |
| lane_sz | input | 2 | 00 8-bit, 01 16-bit, 10 and 11 32-bit lanes |
| is_signed | input | 1 | 1 signed lanes, 0 unsigned lanes |
| opnd_a | input | VEC_W | First packed operand (minuend for subtract) |
| opnd_b | input | VEC_W | Second packed operand (subtrahend for subtract) |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | VEC_W | Packed lane results |

## Verification
The embedded properties watch the timing of the unit on every cycle. They check that the valid flag follows the request by one cycle, that the result holds while no request is present, and that equal operands give zero after a subtract. At the lane level they check that equal operands give the operand back under a plain halving add. Only the bench scenarios can show the rest. These are the rounding and truncation direction, the choice of sign or zero extension, the run-time lane partitioning that keeps carries out of neighbouring lanes, the handling of the reserved codes, and the extreme values that would overflow without the extra bit. The bench checks them against an independent per-lane arithmetic model and against literal values.

// File: rtl/hsv_pkg.sv
// Package: shared encodings for the halving add/subtract unit.
// Assumes the operation and lane-size codes below are fixed at the ports.
package hsv_pkg;
    // Operation select codes; code 3 is unused and decodes as a plain add.
    typedef enum logic [1:0] {
        OP_HADD  = 2'b00,
        OP_RHADD = 2'b01,
        OP_HSUB  = 2'b10,
        OP_SPARE = 2'b11
    } hsv_op_e;

    // Lane width select codes; code 3 is unused and decodes as 32 bits.
    typedef enum logic [1:0] {
        SZ_8     = 2'b00,
        SZ_16    = 2'b01,
        SZ_32    = 2'b10,
        SZ_SPARE = 2'b11
    } hsv_size_e;

    localparam int NUM_SIZES = 3;
    localparam int BASE_LANE_W = 8;
endpackage

// File: rtl/hsv_lane.sv
// Module: one lane of halving arithmetic.
// Widens both operands by one bit (sign or zero), adds or subtracts with an
// optional carry-in of one, and returns the top W bits of the W+1 bit result.
// Assumes sub and rnd are never high together (decoded upstream).
module hsv_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] res
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] addend;
    logic [W:0] total;
    logic       cin;

    // Widen operands and form the W+1 bit sum or difference.
    always_comb begin
        ext_a  = {sgn & a[W-1], a};
        ext_b  = {sgn & b[W-1], b};
        addend = sub ? ~ext_b : ext_b;
        cin    = sub | rnd;
        total  = ext_a + addend + {{W{1'b0}}, cin};
        res    = total[W:1];
    end

    // R9: a plain halving add of a value with itself returns the value.
    always_comb begin
        if (!$isunknown({a, b, sgn, sub, rnd}) && !sub && !rnd && (a == b)) begin
            a_r9_lane_equal_add: assert (res == a)
                else $error("lane halving add of equal operands changed the value");
        end
    end
endmodule

// File: rtl/hsv_lane_array.sv
// Module: a full vector of lanes of one fixed width.
// Slices the operand vectors into VEC_W/LANE_W independent lanes; no signal
// passes between lanes, so carries stop at every lane boundary.
// Assumes VEC_W is a multiple of LANE_W.
module hsv_lane_array #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             sgn,
    input  logic             sub,
    input  logic             rnd,
    output logic [VEC_W-1:0] res
);
    localparam int NUM_LANES = VEC_W / LANE_W;

    // One arithmetic lane per slice.
    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        hsv_lane #(.W(LANE_W)) u_lane (
            .a   (a[ln*LANE_W +: LANE_W]),
            .b   (b[ln*LANE_W +: LANE_W]),
            .sgn (sgn),
            .sub (sub),
            .rnd (rnd),
            .res (res[ln*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/hsv_halving_unit.sv
// Module: packed halving add / rounding halving add / halving subtract.
// Computes all three lane partitionings in parallel, selects one by the
// lane-size input, and registers the result with a valid flag one cycle
// after the request. Assumes VEC_W is 64 or 128.
module hsv_halving_unit
    import hsv_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       lane_sz,
    input  logic             is_signed,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    logic             do_sub;
    logic             do_rnd;
    logic [VEC_W-1:0] part_res [NUM_SIZES];
    logic [VEC_W-1:0] sel_res;

    // Decode the operation into subtract and round-up controls.
    always_comb begin
        do_sub = (op_sel == OP_HSUB);
        do_rnd = (op_sel == OP_RHADD);
    end

    // One lane array per supported lane width (8, 16, 32).
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        localparam int LW = BASE_LANE_W << g;
        hsv_lane_array #(.VEC_W(VEC_W), .LANE_W(LW)) u_arr (
            .a   (opnd_a),
            .b   (opnd_b),
            .sgn (is_signed),
            .sub (do_sub),
            .rnd (do_rnd),
            .res (part_res[g])
        );
    end

    // Pick the partitioning named by the lane-size select.
    always_comb begin
        case (lane_sz)
            SZ_8:    sel_res = part_res[0];
            SZ_16:   sel_res = part_res[1];
            default: sel_res = part_res[2];
        endcase
    end

    // Output register: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= sel_res;
            end
        end
    end

    // R7: a request produces a valid result on the next cycle.
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no result without a request in the previous cycle.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: the result holds while no request arrives.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R9: subtracting equal operands yields zero in every lane.
    a_r9_equal_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_HSUB && opnd_a == opnd_b) |=> (out_data == '0));
endmodule

// File: tb/hsv_halving_unit_tb.sv
module hsv_halving_unit_tb;
    localparam int VEC_W = 128;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [VEC_W-1:0] exp;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       op_sel = 2'b00;
    logic [1:0]       lane_sz = 2'b00;
    logic             is_signed = 1'b0;
    logic [VEC_W-1:0] opnd_a = '0;
    logic [VEC_W-1:0] opnd_b = '0;
    logic             out_valid;
    logic [VEC_W-1:0] out_data;

    int               n_chk = 0;
    int               n_fail = 0;
    bit               done = 0;
    exp_t             sb_q[$];
    logic [VEC_W-1:0] last_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsv_halving_unit #(.VEC_W(VEC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sz(lane_sz), .is_signed(is_signed), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .out_valid(out_valid), .out_data(out_data)
    );

    // Reference: per-lane floor((a op b [+1]) / 2) in wide signed integers.
    function automatic logic [VEC_W-1:0] model(input logic [1:0] op, input logic [1:0] sz,
                                               input logic sg, input logic [VEC_W-1:0] a,
                                               input logic [VEC_W-1:0] b);
        logic [VEC_W-1:0] r;
        int lw;
        r = '0;
        lw = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        for (int i = 0; i < VEC_W / lw; i++) begin
            longint x, y, v;
            x = 0; y = 0;
            for (int k = 0; k < lw; k++) begin
                x[k] = a[i*lw + k];
                y[k] = b[i*lw + k];
            end
            if (sg && x[lw-1]) x = x - (longint'(1) << lw);
            if (sg && y[lw-1]) y = y - (longint'(1) << lw);
            if (op == 2'b10) v = x - y;
            else             v = x + y + ((op == 2'b01) ? 1 : 0);
            v = v >>> 1;
            for (int k = 0; k < lw; k++) r[i*lw + k] = v[k];
        end
        return r;
    endfunction

    function automatic void check(input string tag, input logic [VEC_W-1:0] act,
                                  input logic [VEC_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // Driver: apply one request for one cycle and queue its expected result.
    task automatic send_exp(input logic [1:0] op, input logic [1:0] sz, input logic sg,
                            input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                            input logic [VEC_W-1:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; lane_sz = sz; is_signed = sg;
        opnd_a = a; opnd_b = b;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic send(input logic [1:0] op, input logic [1:0] sz, input logic sg,
                        input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                        input string tag);
        send_exp(op, sz, sg, a, b, model(op, sz, sg, a, b), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a = {4{$urandom}};
            opnd_b = {4{$urandom}};
            op_sel = 2'($urandom);
        end
    endtask

    // Monitor: compare each valid result with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R7: actual unexpected result %h expected none", out_data);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, out_data, it.exp);
            end
            last_out = out_data;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset out_valid", {{(VEC_W-1){1'b0}}, out_valid}, '0);
        check("R8 reset out_data", out_data, '0);
        rst_n = 1'b1;

        // R1: document examples, signed 8-bit truncating add
        send_exp(2'b00, 2'b00, 1'b1, {16{8'hF0}}, {16{8'hF3}}, {16{8'hF1}}, "R1 F0+F3");
        send_exp(2'b00, 2'b00, 1'b1, {16{8'hF1}}, {16{8'hF3}}, {16{8'hF2}}, "R1 F1+F3");
        // R2: rounding add
        send_exp(2'b01, 2'b00, 1'b1, {16{8'hF0}}, {16{8'hF3}}, {16{8'hF2}}, "R2 round");
        // R3: unsigned subtract wraps
        send_exp(2'b10, 2'b00, 1'b0, {16{8'hF0}}, {16{8'hF3}}, {16{8'hFE}}, "R3 wrap");
        // R4: sign versus zero extension
        send_exp(2'b00, 2'b00, 1'b1, {16{8'h80}}, '0, {16{8'hC0}}, "R4 signed");
        send_exp(2'b00, 2'b00, 1'b0, {16{8'h80}}, '0, {16{8'h40}}, "R4 unsigned");
        // R5: carries confined to the selected lane width
        send_exp(2'b00, 2'b01, 1'b0, {8{16'hFFFF}}, {8{16'h0202}}, {8{16'h8100}}, "R5 16-bit");
        send_exp(2'b00, 2'b10, 1'b0, {4{32'hFFFFFFFF}}, {4{32'h02020202}},
                 {4{32'h81010100}}, "R5 32-bit");
        send_exp(2'b00, 2'b11, 1'b0, {4{32'hFFFFFFFF}}, {4{32'h02020202}},
                 {4{32'h81010100}}, "R5 code 11 as 32-bit");
        send_exp(2'b00, 2'b00, 1'b0, {16{8'hFF}}, {16{8'h02}}, {16{8'h80}}, "R5 8-bit");
        // R6: spare op code acts as truncating add
        send_exp(2'b11, 2'b00, 1'b1, {16{8'hF0}}, {16{8'hF3}}, {16{8'hF1}}, "R6 spare op");
        // R9: equal operands
        send_exp(2'b10, 2'b01, 1'b1, {8{16'h1234}}, {8{16'h1234}}, '0, "R9 sub zero");
        send_exp(2'b00, 2'b10, 1'b0, {4{32'hDEADBEEF}}, {4{32'hDEADBEEF}},
                 {4{32'hDEADBEEF}}, "R9 add self");
        // R10: extremes
        send_exp(2'b00, 2'b00, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {16{8'hFF}}, "R10 u add max");
        send_exp(2'b01, 2'b00, 1'b0, {16{8'hFF}}, {16{8'hFF}}, {16{8'hFF}}, "R10 u rnd max");
        send_exp(2'b00, 2'b00, 1'b1, {16{8'h80}}, {16{8'h80}}, {16{8'h80}}, "R10 s min");
        idle(3);

        // R8: output holds while idle inputs change
        idle(4);
        check("R8 hold idle", out_data, last_out);
        check("R8 no valid when idle", {{(VEC_W-1){1'b0}}, out_valid}, '0);

        // R7: back-to-back mixed requests against the model
        for (int i = 0; i < 300; i++) begin
            send(2'($urandom % 3), 2'($urandom), 1'($urandom),
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, "R7 back-to-back");
        end
        idle(3);
        check("R7 all results delivered", VEC_W'(sb_q.size()), '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule